// File: doc/BRIEF.md
# Character-Cell Text Overlay Renderer

This block draws a layer of character-cell text on top of a stream of graphics pixels. Text rows are not stored as one linear buffer. A table in memory holds one 32-bit pointer per text row. When a new text row begins, the block reads that row's pointer from the table. On every scan line it then reads the row's two-byte character cells, converts each one to a glyph slice through a glyph-read port, and keeps the result in a small line store. While the active pixels of the line go by, each pixel is shown either as a colour from a fixed 16-entry palette or as the incoming graphics pixel.

The surrounding timing logic gives the block a frame-start pulse, a line-start pulse during horizontal blank, and a pixel-enable for every active pixel. Software-visible configuration reaches the block as plain inputs: text enable, graphics enable, two transparency selects, the glyph height, the table base address and the row length in bytes. The memory port uses a request/acknowledge handshake. The glyph port is a combinational lookup.

Top module: `tov_text_overlay`

## Requirements
- R1: While `text_on` is 0, `mem_req` stays low and every output pixel equals the `gfx_pix` value sampled with its `pix_en`.
- R2: On the first scan line of each text row, the block reads one 32-bit pointer at byte address `table_base + 4*row`. The row count starts at 0 after `frame_start`. The line within the row starts at 0 and advances by one on each `line_start` after the first line of the frame. After H lines it wraps to 0 and the row count advances.
- R3: On every scan line the block reads the character cells at byte addresses `pointer + 2*c`, for c = 0 up to ncols-1 in ascending order. Here ncols = min(`row_len`/2, MAX_COLS). While a read is waiting for `mem_ack`, `mem_req` and `mem_addr` stay stable.
- R4: In a cell read, `mem_rdata[7:0]` is the character code and `mem_rdata[15:8]` is the attribute. Attribute bits [3:0] select the foreground colour and bits [7:4] select the background colour.
- R5: The glyph slice for a cell is read at `glyph_addr = code*H + line`. H is `glyph_lines`, except that a value of 0 means 16.
- R6: Pixel n of a line (counted from `line_start`) uses cell n/8 and glyph bit 7-(n mod 8). A bit value of 1 selects the foreground colour and 0 selects the background colour.
- R7: The palette maps index i to RGB565. Red is i[2] ? (i[3] ? 31 : 21) : (i[3] ? 10 : 0). Green is i[1] ? (i[3] ? 63 : 42) : (i[3] ? 21 : 0). Blue uses the red rule with i[0].
- R8: When `fg_clear` is 1 and `gfx_on` is 1, foreground pixels show `gfx_pix`.
- R9: When `bg_clear` is 1 and `gfx_on` is 1, background pixels show `gfx_pix`.
- R10: When `gfx_on` is 0, both transparency selects have no effect, and text pixels show palette colours.
- R11: Pixels whose cell index is at or above ncols show `gfx_pix`.
- R12: `out_vld` is high exactly one cycle after each `pix_en`, and `out_pix` carries that pixel's result.
- R13: If a `line_start` arrives in the same cycle as a pixel, that pixel is drawn from the line already fetched. The fetch for the next line then starts, and its pixel count restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| text_on | input | 1 | Text layer enable |
| gfx_on | input | 1 | Graphics layer enabled |
| fg_clear | input | 1 | Foreground pixels transparent |
| bg_clear | input | 1 | Background pixels transparent |
| glyph_lines | input | 4 | Glyph height in lines (0 means 16) |
| table_base | input | 32 | Byte address of the row-pointer table |
| row_len | input | 24 | Bytes per text row (2 per cell) |
| frame_start | input | 1 | Frame start pulse |
| line_start | input | 1 | Scan-line start pulse |
| pix_en | input | 1 | Active pixel strobe |
| gfx_pix | input | 16 | Graphics pixel |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory byte address |
| mem_ack | input | 1 | Memory read acknowledge |
| mem_rdata | input | 32 | Memory read data |
| glyph_addr | output | 12 | Glyph slice address |
| glyph_data | input | 8 | Glyph slice, MSB is leftmost |
| out_pix | output | 16 | Composited pixel |
| out_vld | output | 1 | Composited pixel valid |

## Verification
The fetch for a new line and the drawing of the previous line's last pixel can happen in the same cycle: a `line_start` pulse arrives together with a `pix_en`. The bench provokes this by raising both strobes on the final pixel of a line. It then checks two things. First, that pixel must match the colour predicted from the old line's cells. Second, the following line must show the next glyph line starting again from cell 0, and its memory reads must come in the expected address order.

// File: rtl/tov_pkg.sv
package tov_pkg;

    typedef struct packed {
        logic [7:0] glyph;
        logic [7:0] attr;
    } cell_t;

    typedef enum logic [1:0] {
        F_IDLE,
        F_PTR,
        F_CHR
    } fst_t;

    function automatic logic [15:0] pal16(input logic [3:0] idx);
        logic [4:0] r;
        logic [5:0] g;
        logic [4:0] b;
        r = idx[2] ? (idx[3] ? 5'd31 : 5'd21) : (idx[3] ? 5'd10 : 5'd0);
        g = idx[1] ? (idx[3] ? 6'd63 : 6'd42) : (idx[3] ? 6'd21 : 6'd0);
        b = idx[0] ? (idx[3] ? 5'd31 : 5'd21) : (idx[3] ? 5'd10 : 5'd0);
        return {r, g, b};
    endfunction

endpackage

// File: rtl/tov_fetch.sv
module tov_fetch
    import tov_pkg::*;
#(
    parameter int MAX_COLS = 80,
    parameter int ROW_W    = 8,
    localparam int COL_W   = $clog2(MAX_COLS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             text_on,
    input  logic [3:0]       lines_cfg,
    input  logic [31:0]      table_base,
    input  logic [23:0]      row_len,
    input  logic             frame_start,
    input  logic             line_start,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic [11:0]      glyph_addr,
    input  logic [7:0]       glyph_data,
    output logic             wr_en,
    output logic [COL_W-1:0] wr_idx,
    output cell_t            wr_cell,
    output logic [COL_W-1:0] ncols
);

    typedef struct packed {
        fst_t             st;
        logic [31:0]      ptr;
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] ncols;
        logic [3:0]       line;
        logic [ROW_W-1:0] row;
        logic             first;
    } fstate_t;

    fstate_t q, d;

    logic [4:0]       lpc;
    logic [23:0]      half;
    logic [COL_W-1:0] ncols_cl;
    logic [3:0]       nl;
    logic [ROW_W-1:0] nr;

    always_comb begin
        lpc      = (lines_cfg == 4'd0) ? 5'd16 : {1'b0, lines_cfg};
        half     = row_len >> 1;
        ncols_cl = (half > 24'(MAX_COLS)) ? COL_W'(MAX_COLS) : half[COL_W-1:0];
        if (q.first) begin
            nl = 4'd0;
            nr = q.row;
        end else if ({1'b0, q.line} == lpc - 5'd1) begin
            nl = 4'd0;
            nr = q.row + 1'b1;
        end else begin
            nl = q.line + 4'd1;
            nr = q.row;
        end

        d          = q;
        mem_req    = 1'b0;
        mem_addr   = '0;
        glyph_addr = '0;
        wr_en      = 1'b0;
        wr_idx     = q.col;
        wr_cell    = '0;

        if (frame_start) begin
            d.st    = F_IDLE;
            d.first = 1'b1;
            d.line  = '0;
            d.row   = '0;
        end else if (!text_on) begin
            d.st = F_IDLE;
        end else if (line_start) begin
            d.first = 1'b0;
            d.line  = nl;
            d.row   = nr;
            d.col   = '0;
            d.ncols = ncols_cl;
            if (ncols_cl == '0) begin
                d.st = F_IDLE;
            end else if (nl == 4'd0) begin
                d.st = F_PTR;
            end else begin
                d.st = F_CHR;
            end
        end else begin
            case (q.st)
                F_PTR: begin
                    mem_req  = 1'b1;
                    mem_addr = table_base + 32'({q.row, 2'b00});
                    if (mem_ack) begin
                        d.ptr = mem_rdata;
                        d.st  = F_CHR;
                    end
                end
                F_CHR: begin
                    mem_req    = 1'b1;
                    mem_addr   = q.ptr + 32'({q.col, 1'b0});
                    glyph_addr = 12'(mem_rdata[7:0]) * 12'(lpc) + 12'(q.line);
                    if (mem_ack) begin
                        wr_en   = 1'b1;
                        wr_cell = '{glyph: glyph_data, attr: mem_rdata[15:8]};
                        d.col   = q.col + 1'b1;
                        if (q.col == q.ncols - 1'b1) begin
                            d.st = F_IDLE;
                        end
                    end
                end
                default: d.st = F_IDLE;
            endcase
        end
        ncols = q.ncols;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: F_IDLE, ptr: '0, col: '0, ncols: '0, line: '0, row: '0, first: 1'b1};
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/tov_linebuf.sv
module tov_linebuf
    import tov_pkg::*;
#(
    parameter int MAX_COLS = 80,
    localparam int COL_W   = $clog2(MAX_COLS + 1)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [COL_W-1:0] wr_idx,
    input  cell_t            wr_cell,
    input  logic [COL_W-1:0] rd_idx,
    output cell_t            rd_cell
);

    cell_t store_q [MAX_COLS];

    for (genvar gi = 0; gi < MAX_COLS; gi++) begin : g_cell
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == COL_W'(gi)) begin
                store_q[gi] <= wr_cell;
            end
        end
    end

    always_comb begin
        rd_cell = '0;
        for (int i = 0; i < MAX_COLS; i++) begin
            if (rd_idx == COL_W'(i)) begin
                rd_cell = store_q[i];
            end
        end
    end

endmodule

// File: rtl/tov_compose.sv
module tov_compose
    import tov_pkg::*;
#(
    parameter int MAX_COLS = 80,
    localparam int COL_W   = $clog2(MAX_COLS + 1),
    localparam int PX_W    = COL_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             text_on,
    input  logic             gfx_on,
    input  logic             fg_clear,
    input  logic             bg_clear,
    input  logic             line_start,
    input  logic             pix_en,
    input  logic [15:0]      gfx_pix,
    input  logic [COL_W-1:0] ncols,
    output logic [COL_W-1:0] rd_idx,
    input  cell_t            rd_cell,
    output logic [15:0]      out_pix,
    output logic             out_vld
);

    typedef struct packed {
        logic [PX_W-1:0] px;
        logic [15:0]     pix;
        logic            vld;
    } cstate_t;

    cstate_t q, d;

    logic [COL_W-1:0] col;
    logic             fg;
    logic [3:0]       idx;
    logic             clr;
    logic [15:0]      sel;

    always_comb begin
        col    = q.px[PX_W-1:3];
        rd_idx = col;
        fg     = rd_cell.glyph[3'd7 - q.px[2:0]];
        idx    = fg ? rd_cell.attr[3:0] : rd_cell.attr[7:4];
        clr    = fg ? fg_clear : bg_clear;
        if (!text_on || col >= ncols) begin
            sel = gfx_pix;
        end else if (clr && gfx_on) begin
            sel = gfx_pix;
        end else begin
            sel = pal16(idx);
        end

        d     = q;
        d.vld = pix_en;
        if (pix_en) begin
            d.pix = sel;
            if (q.px != '1) begin
                d.px = q.px + 1'b1;
            end
        end
        if (line_start) begin
            d.px = '0;
        end
        out_pix = q.pix;
        out_vld = q.vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/tov_text_overlay.sv
module tov_text_overlay
    import tov_pkg::*;
#(
    parameter int MAX_COLS = 80,
    parameter int ROW_W    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        text_on,
    input  logic        gfx_on,
    input  logic        fg_clear,
    input  logic        bg_clear,
    input  logic [3:0]  glyph_lines,
    input  logic [31:0] table_base,
    input  logic [23:0] row_len,
    input  logic        frame_start,
    input  logic        line_start,
    input  logic        pix_en,
    input  logic [15:0] gfx_pix,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic [11:0] glyph_addr,
    input  logic [7:0]  glyph_data,
    output logic [15:0] out_pix,
    output logic        out_vld
);

    localparam int COL_W = $clog2(MAX_COLS + 1);

    logic             wr_en;
    logic [COL_W-1:0] wr_idx;
    cell_t            wr_cell;
    logic [COL_W-1:0] ncols;
    logic [COL_W-1:0] rd_idx;
    cell_t            rd_cell;

    tov_fetch #(.MAX_COLS(MAX_COLS), .ROW_W(ROW_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .text_on    (text_on),
        .lines_cfg  (glyph_lines),
        .table_base (table_base),
        .row_len    (row_len),
        .frame_start(frame_start),
        .line_start (line_start),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .glyph_addr (glyph_addr),
        .glyph_data (glyph_data),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_cell    (wr_cell),
        .ncols      (ncols)
    );

    tov_linebuf #(.MAX_COLS(MAX_COLS)) u_linebuf (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_cell(wr_cell),
        .rd_idx (rd_idx),
        .rd_cell(rd_cell)
    );

    tov_compose #(.MAX_COLS(MAX_COLS)) u_compose (
        .clk       (clk),
        .rst_n     (rst_n),
        .text_on   (text_on),
        .gfx_on    (gfx_on),
        .fg_clear  (fg_clear),
        .bg_clear  (bg_clear),
        .line_start(line_start),
        .pix_en    (pix_en),
        .gfx_pix   (gfx_pix),
        .ncols     (ncols),
        .rd_idx    (rd_idx),
        .rd_cell   (rd_cell),
        .out_pix   (out_pix),
        .out_vld   (out_vld)
    );

endmodule

// File: rtl/tov_text_overlay_chk.sv
module tov_text_overlay_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        text_on,
    input logic        frame_start,
    input logic        line_start,
    input logic        pix_en,
    input logic [15:0] gfx_pix,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic [15:0] out_pix,
    input logic        out_vld
);

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !text_on |-> !mem_req); // R1

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !text_on) |=> (out_pix == $past(gfx_pix))); // R1

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |=> out_vld); // R12

    AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> !out_vld); // R12

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !line_start && !frame_start)
        |=> (!text_on || line_start || frame_start || (mem_req && $stable(mem_addr)))); // R3

endmodule

bind tov_text_overlay tov_text_overlay_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .text_on    (text_on),
    .frame_start(frame_start),
    .line_start (line_start),
    .pix_en     (pix_en),
    .gfx_pix    (gfx_pix),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .out_pix    (out_pix),
    .out_vld    (out_vld)
);

// File: tb/tov_text_overlay_bench.sv
module tov_text_overlay_bench;

    localparam int MAXC = 80;
    localparam int FW   = 2 * MAXC + 20;
    localparam int TB   = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        text_on = 1'b0, gfx_on = 1'b1, fg_clear = 1'b0, bg_clear = 1'b0;
    logic [3:0]  glyph_lines = 4'd0;
    logic [31:0] table_base = TB;
    logic [23:0] row_len = 24'd20;
    logic        frame_start = 1'b0, line_start = 1'b0, pix_en = 1'b0;
    logic [15:0] gfx_pix = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [11:0] glyph_addr;
    logic [7:0]  glyph_data;
    logic [15:0] out_pix;
    logic        out_vld;

    always #5 clk = ~clk;

    tov_text_overlay u_tov_text_overlay (
        .clk(clk), .rst_n(rst_n), .text_on(text_on), .gfx_on(gfx_on),
        .fg_clear(fg_clear), .bg_clear(bg_clear), .glyph_lines(glyph_lines),
        .table_base(table_base), .row_len(row_len), .frame_start(frame_start),
        .line_start(line_start), .pix_en(pix_en), .gfx_pix(gfx_pix),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .glyph_addr(glyph_addr), .glyph_data(glyph_data),
        .out_pix(out_pix), .out_vld(out_vld)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] mem [int];
    logic [15:0] exp_q [$];
    string       tag_q [$];
    int          exp_addr [$];

    int m_row, m_line, H, ncols;
    bit m_first;

    function automatic logic [7:0] rd8(int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] font(int a);
        return 8'((a * 73) ^ (a >> 3) ^ 8'h5a);
    endfunction

    assign glyph_data = font(int'(glyph_addr));

    function automatic logic [15:0] pal(logic [3:0] i);
        int r, g, b;
        r = i[2] ? (i[3] ? 31 : 21) : (i[3] ? 10 : 0);
        g = i[1] ? (i[3] ? 63 : 42) : (i[3] ? 21 : 0);
        b = i[0] ? (i[3] ? 31 : 21) : (i[3] ? 10 : 0);
        return {5'(r), 6'(g), 5'(b)};
    endfunction

    function automatic int ptr_of(int r);
        int a = TB + 4 * r;
        return {rd8(a + 3), rd8(a + 2), rd8(a + 1), rd8(a)};
    endfunction

    function automatic void check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    // memory responder: one acknowledge per request, sampled away from edges
    always begin
        @(posedge clk);
        #2;
        if (mem_req && !mem_ack) begin
            int a;
            a = int'(mem_addr);
            if (exp_addr.size() == 0) begin
                check(0, "R1,R2,R3 unexpected read", a, -1);
            end else begin
                int e;
                e = exp_addr.pop_front();
                check(a == e, "R2,R3 read address", a, e);
            end
            mem_ack   <= 1'b1;
            mem_rdata <= {rd8(a + 3), rd8(a + 2), rd8(a + 1), rd8(a)};
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_vld && !done) begin
            if (exp_q.size() == 0) begin
                check(0, "R12 unexpected pixel", out_pix, 0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_pix == e, t, out_pix, e);
            end
        end
    end

    function automatic void model_next_line();
        if (!text_on) return;
        if (m_first) m_first = 0;
        else if (m_line == H - 1) begin m_line = 0; m_row++; end
        else m_line++;
        if (ncols > 0) begin
            if (m_line == 0) exp_addr.push_back(TB + 4 * m_row);
            for (int c = 0; c < ncols; c++) exp_addr.push_back(ptr_of(m_row) + 2 * c);
        end
    endfunction

    function automatic void push_pix(int n, logic [15:0] g, string base);
        int c = n / 8;
        int p, code;
        logic [7:0] attr, gl;
        logic b, clr;
        logic [3:0] idx;
        if (!text_on) begin exp_q.push_back(g); tag_q.push_back("R1 pass-through"); return; end
        if (c >= ncols) begin exp_q.push_back(g); tag_q.push_back("R11 beyond cells"); return; end
        p    = ptr_of(m_row);
        code = int'(rd8(p + 2 * c));
        attr = rd8(p + 2 * c + 1);
        gl   = font(code * H + m_line);
        b    = gl[7 - (n % 8)];
        idx  = b ? attr[3:0] : attr[7:4];
        clr  = b ? fg_clear : bg_clear;
        exp_q.push_back((clr && gfx_on) ? g : pal(idx));
        tag_q.push_back(base);
    endfunction

    task automatic frame_go();
        H     = (glyph_lines == 0) ? 16 : int'(glyph_lines);
        ncols = (int'(row_len) / 2 > MAXC) ? MAXC : int'(row_len) / 2;
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        m_row = 0; m_line = 0; m_first = 1;
    endtask

    task automatic new_line();
        @(negedge clk); line_start = 1'b1; model_next_line();
        @(negedge clk); line_start = 1'b0;
        repeat (FW) @(negedge clk);
    endtask

    task automatic run_pixels(int npix, bit overlap, string base);
        for (int n = 0; n < npix; n++) begin
            @(negedge clk);
            pix_en  = 1'b1;
            gfx_pix = 16'(n * 977 + m_line * 31 + m_row * 5 + 1);
            push_pix(n, gfx_pix, base);
            if (overlap && n == npix - 1) begin
                line_start = 1'b1;
                model_next_line();
            end
        end
        @(negedge clk);
        pix_en = 1'b0; line_start = 1'b0;
        repeat (overlap ? FW : 3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 4; r++) begin
            int p = 32'h1000 + r * 32'h200;
            for (int k = 0; k < 4; k++) mem[TB + 4 * r + k] = 8'(p >> (8 * k));
            for (int c = 0; c < MAXC; c++) begin
                mem[p + 2 * c]     = 8'(r * 7 + c * 13 + 3);
                mem[p + 2 * c + 1] = {4'(c + r), 4'(c * 3 + r + 1)};
            end
        end
        repeat (3) @(negedge clk);
        check(out_vld == 1'b0, "R12 reset out_vld", out_vld, 0);
        check(mem_req == 1'b0, "R1 reset mem_req", mem_req, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: text off, pure pass-through, no reads
        text_on = 1'b0;
        frame_go();
        new_line();
        run_pixels(40, 0, "R1");
        check(mem_req == 1'b0, "R1 no request", mem_req, 0);

        // R2..R7, R11: 16-line glyphs, 10 cells, crossing a text row
        text_on = 1'b1; glyph_lines = 4'd0; row_len = 24'd20;
        frame_go();
        for (int l = 0; l < 18; l++) begin
            new_line();
            run_pixels(96, 0, "R2,R4,R5,R6,R7");
        end

        // R8, R9, R10 with 3-line glyphs
        glyph_lines = 4'd3; row_len = 24'd16;
        frame_go();
        fg_clear = 1'b1; bg_clear = 1'b0; gfx_on = 1'b1;
        for (int l = 0; l < 3; l++) begin new_line(); run_pixels(64, 0, "R8,R5 fg clear"); end
        fg_clear = 1'b0; bg_clear = 1'b1;
        for (int l = 0; l < 3; l++) begin new_line(); run_pixels(64, 0, "R9 bg clear"); end
        fg_clear = 1'b1; bg_clear = 1'b1; gfx_on = 1'b0;
        for (int l = 0; l < 2; l++) begin new_line(); run_pixels(64, 0, "R10 gfx off"); end
        fg_clear = 1'b0; bg_clear = 1'b0; gfx_on = 1'b1;

        // R3: row length above capacity is clamped
        glyph_lines = 4'd0; row_len = 24'd200;
        frame_go();
        new_line();
        run_pixels((MAXC + 1) * 8, 0, "R3 clamp");
        check(exp_addr.size() == 0, "R3 all cells read", exp_addr.size(), 0);

        // R13: line start together with the last pixel
        glyph_lines = 4'd2; row_len = 24'd12;
        frame_go();
        new_line();
        run_pixels(56, 1, "R13 overlap old line");
        run_pixels(56, 1, "R13 overlap new line");
        run_pixels(56, 0, "R13 after wrap");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R12 pixel count", exp_q.size(), 0);
        check(exp_addr.size() == 0, "R2,R3 read count", exp_addr.size(), 0);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule